// File: doc/BRIEF.md
# Write-One-to-Act GPIO Port Register

This block is one 32-bit register that controls up to eight general-purpose pins. Every writable bit is an action strobe. A 1 performs the action and a 0 does nothing. Software can therefore change one pin with a single word write, without first reading the register. The lower half of the word holds a pair of strobes per pin that drive the output latch high or low. The upper half holds a pair per pin that turns the output driver on or off.

A read does not return the last word written. It returns a status word at the same bit positions:

- whether the driver is on,
- the latch value while the pin drives,
- the synchronized input level while the pin is an input.

There is no toggle action. To invert a pin, software reads the latch and then writes the opposite strobe. The bus has no address: a write strobe, 32-bit write data and combinational read data.

Top module: `gpio_wo_port`

## Requirements
- R1: After reset every driver is off (`pinOe` = 0), every latch is low (`pinOut` = 0) and `rdData` reads 0 until an input is sampled high.
- R2: When `wrEn` is high and bit 2n+1 of `wrData` is 1 (and bit 2n is 0), the latch of pin n is high from the next clock edge onward.
- R3: When `wrEn` is high and bit 2n of `wrData` is 1, the latch of pin n is low from the next edge. This holds even when bit 2n+1 is also 1, so clear wins.
- R4: When `wrEn` is high, bit 16+2n turns pin n's driver on and bit 17+2n turns it off from the next edge. When both bits are 1, off wins.
- R5: A 0 in any strobe bit, or any word presented while `wrEn` is low, leaves that pin's latch and driver unchanged.
- R6: Read bit 16+2n is 1 exactly while pin n's driver is on.
- R7: Read bit 2n equals pin n's latch while its driver is on, and 0 while it is off.
- R8: Read bit 2n+1 equals pin n's input, delayed by two clock edges through a synchronizer, while the driver is off. It is 0 while the driver is on.
- R9: Read bit 17+2n always reads 0.
- R10: There is no toggle. Inverting a pin is done by reading bit 2n and then writing the opposite strobe, and this takes effect one edge after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one word per cycle |
| wrData | input | 32 | Strobe word |
| rdData | output | 32 | Status word |
| pinIn | input | NUM_PINS | Pin input levels, asynchronous |
| pinOut | output | NUM_PINS | Output latch values |
| pinOe | output | NUM_PINS | Output driver enables |

## Verification
A write presented before an edge shows on `pinOut`, `pinOe` and the driver and latch read bits right after that edge. A change on `pinIn` reaches read bit 2n+1 only after the second edge. The bench drives inputs on the falling edge and updates its reference model on the rising edge. It then compares every output and every read bit against the model at the next falling edge, so each result is sampled in the cycle it is due. Directed sequences cover reset, both strobe conflicts, zero-bit writes, idle cycles, the read-then-write toggle and the two-edge input delay. Random traffic follows the directed sequences.

// File: rtl/gpio_wo_pkg.sv
package gpio_wo_pkg;
  localparam int MAX_PINS = 8;
  localparam int REG_W    = 32;
  localparam int HALF_W   = REG_W / 2;

  typedef struct packed {
    logic [MAX_PINS-1:0] setLat;
    logic [MAX_PINS-1:0] clrLat;
    logic [MAX_PINS-1:0] drvOn;
    logic [MAX_PINS-1:0] drvOff;
  } pinCmd_t;
endpackage

// File: rtl/gpio_wo_decode.sv
module gpio_wo_decode
  import gpio_wo_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output pinCmd_t          cmd
);
  for (genvar n = 0; n < MAX_PINS; n++) begin : g_pin
    if (n < NUM_PINS) begin : g_used
      assign cmd.clrLat[n] = wrEn & wrData[2*n];
      assign cmd.setLat[n] = wrEn & wrData[2*n+1];
      assign cmd.drvOn[n]  = wrEn & wrData[HALF_W+2*n];
      assign cmd.drvOff[n] = wrEn & wrData[HALF_W+2*n+1];
    end else begin : g_unused
      assign cmd.clrLat[n] = 1'b0;
      assign cmd.setLat[n] = 1'b0;
      assign cmd.drvOn[n]  = 1'b0;
      assign cmd.drvOff[n] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_wo_core.sv
module gpio_wo_core
  import gpio_wo_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  pinCmd_t             cmd,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [REG_W-1:0]    rdData
);
  logic [NUM_PINS-1:0] latchQ, oeQ;
  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      oeQ    <= '0;
    end else begin
      for (int n = 0; n < NUM_PINS; n++) begin
        if (cmd.clrLat[n])      latchQ[n] <= 1'b0;
        else if (cmd.setLat[n]) latchQ[n] <= 1'b1;
        if (cmd.drvOff[n])      oeQ[n] <= 1'b0;
        else if (cmd.drvOn[n])  oeQ[n] <= 1'b1;
      end
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= pinIn;
      else             syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end

  always_comb begin
    rdData = '0;
    for (int n = 0; n < NUM_PINS; n++) begin
      rdData[2*n]          = oeQ[n] & latchQ[n];
      rdData[2*n+1]        = ~oeQ[n] & syncQ[SYNC_STAGES-1][n];
      rdData[HALF_W+2*n]   = oeQ[n];
    end
  end

  assign pinOut = latchQ;
  assign pinOe  = oeQ;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
    a_r2_set_latch: assert property (@(posedge clk) disable iff (!rstN)
      cmd.setLat[n] && !cmd.clrLat[n] |=> pinOut[n]);
    a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
      cmd.clrLat[n] |=> !pinOut[n]);
    a_r4_off_wins: assert property (@(posedge clk) disable iff (!rstN)
      cmd.drvOff[n] |=> !pinOe[n]);
    a_r4_on: assert property (@(posedge clk) disable iff (!rstN)
      cmd.drvOn[n] && !cmd.drvOff[n] |=> pinOe[n]);
    a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
      !cmd.setLat[n] && !cmd.clrLat[n] && !cmd.drvOn[n] && !cmd.drvOff[n]
      |=> $stable(pinOut[n]) && $stable(pinOe[n]));
  end
endmodule

// File: rtl/gpio_wo_port.sv
module gpio_wo_port
  import gpio_wo_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);
  pinCmd_t cmd;

  gpio_wo_decode #(.NUM_PINS(NUM_PINS)) u_decode (
    .wrEn(wrEn), .wrData(wrData), .cmd(cmd)
  );

  gpio_wo_core #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .rdData(rdData)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_rdchk
    a_r7_latch_only_when_driving: assert property (@(posedge clk) disable iff (!rstN)
      rdData[2*n] |-> pinOe[n] && pinOut[n]);
    a_r8_input_only_when_released: assert property (@(posedge clk) disable iff (!rstN)
      rdData[2*n+1] |-> !pinOe[n]);
  end
endmodule

// File: tb/sim_gpio_wo_port.sv
module sim_gpio_wo_port;
  localparam int NP = 8;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [NP-1:0] pinIn = '0, pinOut, pinOe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit refLat[NP], refOe[NP], refS1[NP], refS2[NP];

  gpio_wo_port #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    for (int n = 0; n < NP; n++) begin
      if (!rstN) begin
        refLat[n] = 0; refOe[n] = 0; refS1[n] = 0; refS2[n] = 0;
      end else begin
        if (wrEn && wrData[2*n])         refLat[n] = 0;
        else if (wrEn && wrData[2*n+1])  refLat[n] = 1;
        if (wrEn && wrData[17+2*n])      refOe[n] = 0;
        else if (wrEn && wrData[16+2*n]) refOe[n] = 1;
        refS2[n] = refS1[n];
        refS1[n] = pinIn[n];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // compare every output against the model on each falling edge
  always @(negedge clk) if (rstN && !done) begin
    for (int n = 0; n < NP; n++) begin
      chk(pinOut[n] == refLat[n], "R2/R3 pinOut", pinOut[n], refLat[n]);
      chk(pinOe[n] == refOe[n], "R4 pinOe", pinOe[n], refOe[n]);
      chk(rdData[16+2*n] == refOe[n], "R6 drive bit", rdData[16+2*n], refOe[n]);
      chk(rdData[2*n] == (refOe[n] & refLat[n]), "R7 latch bit", rdData[2*n], refOe[n] & refLat[n]);
      chk(rdData[2*n+1] == (!refOe[n] & refS2[n]), "R8 input bit", rdData[2*n+1], !refOe[n] & refS2[n]);
      chk(rdData[17+2*n] == 1'b0, "R9 unused bit", rdData[17+2*n], 0);
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  initial begin
    logic [NP-1:0] snapOut, snapOe;
    logic [31:0] r;
    repeat (3) @(negedge clk);
    chk(pinOe == '0 && pinOut == '0 && rdData == '0, "R1 reset", rdData, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(pinOe == '0 && pinOut == '0 && rdData == '0, "R1 after release", rdData, 0);
    // R4: enable pins 0 and 3, R2: set pin 3
    wr(32'h0001_0000 | 32'h0001_0000 << 6 | 32'h2 << 6);
    chk(pinOe == 8'h09 && pinOut == 8'h08, "R2/R4 directed", {pinOe, pinOut}, 16'h0908);
    chk(rdData == 32'h0041_0040, "R7 directed read", rdData, 32'h0041_0040);
    // R3: set and clear together on pin 3, clear wins
    wr(32'h3 << 6);
    chk(pinOut[3] == 1'b0, "R3 clear wins", pinOut[3], 0);
    // R4: on and off together on pin 0, off wins
    wr(32'h3 << 16);
    chk(pinOe[0] == 1'b0, "R4 off wins", pinOe[0], 0);
    // R5: zero word write and idle data leave state
    wr(32'h2 << 10 | 32'h1 << 26);
    snapOut = pinOut; snapOe = pinOe;
    wr(32'h0);
    @(negedge clk); wrData = 32'hFFFF_FFFF;
    @(negedge clk); wrData = '0;
    chk(pinOut == snapOut && pinOe == snapOe, "R5 no effect", {pinOut, pinOe}, {snapOut, snapOe});
    // R10: read-then-write inversion of pin 5 (driving high)
    r = rdData;
    wr(r[10] ? 32'h1 << 10 : 32'h2 << 10);
    chk(pinOut[5] == 1'b0 && rdData[10] == 1'b0, "R10 invert", pinOut[5], 0);
    // R8: input on released pin 1 appears after two edges
    @(negedge clk); pinIn[1] = 1'b1;
    @(negedge clk);
    chk(rdData[3] == 1'b0, "R8 one edge", rdData[3], 0);
    @(negedge clk);
    chk(rdData[3] == 1'b1, "R8 two edges", rdData[3], 1);
    wr(32'h1 << 18);
    chk(rdData[3] == 1'b0 && rdData[18] == 1'b1, "R8 masked when driving", rdData[3], 0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wrEn = ($urandom_range(0, 1) == 1);
      wrData = $urandom();
      if ($urandom_range(0, 3) == 0) pinIn = NP'($urandom());
    end
    @(negedge clk); wrEn = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule